// File: doc/BRIEF.md
# Machine-Level Trap Control Unit

This block holds the machine-level trap state of a small in-order core and works out where the program counter goes whenever control leaves normal flow. The pipeline presents synchronous exception requests with a cause code and the address of the instruction involved. Three interrupt lines (external, software, timer) may arrive at any time. A return-from-trap strobe ends a handler. Software reads and writes the trap registers through a simple register port.

In the cycle a trap or return is requested, the block raises a redirect-valid output and drives the target address on combinational paths. At the next clock edge it updates its cause, saved-PC and status registers. The target comes from the trap-vector register. In direct mode every trap goes to the base address. In vectored mode an interrupt goes to the base address plus four times its cause code, while an exception still goes to the base address.

Top module: `mtrap_unit`

## Requirements
- R1: After reset every register reads zero through the register port and redir_valid is 0 while no request is presented.
- R2: On a trap the cause register (select 3) gets its top bit set to 1 for an interrupt and 0 for an exception, with the cause code zero-extended into the low bits. Interrupt codes are software 3, timer 7 and external 11.
- R3: The trap-vector register (select 2) keeps the mode in bits [1:0] and the base in bits [XLEN-1:2]. A written mode of 2 or 3 is stored and read back as 0.
- R4: In direct mode (mode 0) every trap drives redir_pc to the base address, which is the register value with bits [1:0] cleared.
- R5: In vectored mode (mode 1) an interrupt drives redir_pc to base + 4 × code, and an exception drives it to base.
- R6: The saved-PC register (select 4) captures trap_pc with bits [1:0] cleared on each trap. A software write also reads back with bits [1:0] as zero.
- R7: When ret_req is high and no trap is taken, redir_valid is 1 and redir_pc equals the saved PC. At the clock edge the status global enable (bit 3) takes the saved enable (bit 7), and bit 7 becomes 1.
- R8: An interrupt is taken only when status bit 3 is set and the source's enable bit is set in the enable register (select 1). The enable bit sits at the position equal to the source's cause code (3, 7, 11).
- R9: On trap entry, status bit 7 takes the previous value of bit 3, and bit 3 is cleared.
- R10: An exception request beats any interrupt. Among enabled interrupts the priority is external, then software, then timer. A trap beats a simultaneous return.
- R11: redir_valid and redir_pc respond in the same cycle as the request. A register write presented in a trap or return cycle is discarded.
- R12: The select codes are 0 status, 1 enable, 2 vector, 3 cause and 4 saved PC. Selects 5 to 7 read zero. Status implements only bits 3 and 7, and enable implements only bits 3, 7 and 11. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Exception cause code |
| trap_pc | input | XLEN | Address to save on a trap |
| irq_ext | input | 1 | External interrupt pending |
| irq_sw | input | 1 | Software interrupt pending |
| irq_tmr | input | 1 | Timer interrupt pending |
| ret_req | input | 1 | Return-from-trap strobe |
| csr_we | input | 1 | Register write enable |
| csr_sel | input | 3 | Register select |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data (combinational) |
| redir_valid | output | 1 | PC redirect request |
| redir_pc | output | XLEN | Redirect target address |

## Verification
The bench builds the unit with XLEN = 16 and CODE_W = 4. At that size all sixteen exception codes can be swept in both vector modes. Every combination of global enable, the three per-source enables and the three pending lines (128 cases) can also be swept, with the winner and its vectored target computed arithmetically. The narrow width also makes the discarded-write, alignment and unimplemented-bit checks readable as whole register values.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_IEN   = 3'd1,
    SEL_VEC   = 3'd2,
    SEL_CAUSE = 3'd3,
    SEL_EPC   = 3'd4
  } csr_sel_e;

  localparam int unsigned CODE_SW  = 3;
  localparam int unsigned CODE_TMR = 7;
  localparam int unsigned CODE_EXT = 11;
  localparam int unsigned ST_IE    = 3;
  localparam int unsigned ST_PIE   = 7;
  localparam int unsigned N_SRC    = 3;

  // source index: 0 timer, 1 software, 2 external
  function automatic int unsigned src_code(input int unsigned idx);
    case (idx)
      0:       return CODE_TMR;
      1:       return CODE_SW;
      default: return CODE_EXT;
    endcase
  endfunction

  function automatic logic [1:0] legal_mode(input logic [1:0] m);
    return (m == 2'd1) ? 2'd1 : 2'd0;
  endfunction
endpackage

// File: rtl/mtrap_arb.sv
module mtrap_arb
  import mtrap_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [N_SRC-1:0]  pend,
  input  logic [N_SRC-1:0]  src_en,
  input  logic              gie,
  output logic              take,
  output logic              is_irq,
  output logic [CODE_W-1:0] code
);
  logic [N_SRC-1:0] live;
  assign live = pend & src_en & {N_SRC{gie}};

  always_comb begin
    take   = 1'b0;
    is_irq = 1'b0;
    code   = '0;
    if (exc_req) begin
      take = 1'b1;
      code = exc_code;
    end else begin
      // lowest index first so the highest index (external) wins last
      for (int i = 0; i < N_SRC; i++) begin
        if (live[i]) begin
          take   = 1'b1;
          is_irq = 1'b1;
          code   = CODE_W'(src_code(i));
        end
      end
    end
  end
endmodule

// File: rtl/mtrap_target.sv
module mtrap_target #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic [XLEN-3:0]   base,
  input  logic [1:0]        mode,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   pc
);
  function automatic logic [XLEN-1:0] vec_target(
    input logic [XLEN-3:0] b, input logic [1:0] m,
    input logic irq, input logic [CODE_W-1:0] c);
    logic [XLEN-1:0] start;
    start = {b, 2'b00};
    if (m == 2'd1 && irq) return start + (XLEN'(c) << 2);
    return start;
  endfunction

  assign pc = vec_target(base, mode, is_irq, code);
endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_take,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              ret_take,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata,
  output logic              gie,
  output logic [N_SRC-1:0]  src_en,
  output logic [XLEN-3:0]   vec_base,
  output logic [1:0]        vec_mode,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause
);
  logic            ie_q, pie_q;
  logic [N_SRC-1:0] en_q;
  logic [XLEN-3:0] base_q;
  logic [1:0]      mode_q;
  logic [XLEN-1:0] epc_q, cause_q;
  logic [XLEN-1:0] stat_rd, ien_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      pie_q   <= 1'b0;
      base_q  <= '0;
      mode_q  <= '0;
      epc_q   <= '0;
      cause_q <= '0;
    end else if (trap_take) begin
      pie_q   <= ie_q;
      ie_q    <= 1'b0;
      epc_q   <= {trap_pc[XLEN-1:2], 2'b00};
      cause_q <= {trap_irq, {(XLEN-1-CODE_W){1'b0}}, trap_code};
    end else if (ret_take) begin
      ie_q  <= pie_q;
      pie_q <= 1'b1;
    end else if (wr_en) begin
      case (sel)
        SEL_STAT: begin
          ie_q  <= wdata[ST_IE];
          pie_q <= wdata[ST_PIE];
        end
        SEL_VEC: begin
          base_q <= wdata[XLEN-1:2];
          mode_q <= legal_mode(wdata[1:0]);
        end
        SEL_CAUSE: cause_q <= wdata;
        SEL_EPC:   epc_q   <= {wdata[XLEN-1:2], 2'b00};
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_en
      localparam int unsigned POS = src_code(g);
      always_ff @(posedge clk) begin
        if (!rst_n) en_q[g] <= 1'b0;
        else if (wr_en && !trap_take && !ret_take && sel == SEL_IEN)
          en_q[g] <= wdata[POS];
      end
    end
  endgenerate

  always_comb begin
    stat_rd = '0;
    stat_rd[ST_IE]  = ie_q;
    stat_rd[ST_PIE] = pie_q;
    ien_rd = '0;
    for (int i = 0; i < N_SRC; i++) ien_rd[src_code(i)] = en_q[i];
    case (sel)
      SEL_STAT:  rdata = stat_rd;
      SEL_IEN:   rdata = ien_rd;
      SEL_VEC:   rdata = {base_q, mode_q};
      SEL_CAUSE: rdata = cause_q;
      SEL_EPC:   rdata = epc_q;
      default:   rdata = '0;
    endcase
  end

  assign gie      = ie_q;
  assign src_en   = en_q;
  assign vec_base = base_q;
  assign vec_mode = mode_q;
  assign epc      = epc_q;
  assign cause    = cause_q;
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              irq_ext,
  input  logic              irq_sw,
  input  logic              irq_tmr,
  input  logic              ret_req,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);
  logic              trap_take, trap_irq, ret_take, wr_en, gie;
  logic [CODE_W-1:0] trap_code;
  logic [N_SRC-1:0]  src_en;
  logic [XLEN-3:0]   vec_base;
  logic [1:0]        vec_mode;
  logic [XLEN-1:0]   epc_val, cause_val, target_pc;

  mtrap_arb #(.CODE_W(CODE_W)) u_arb (
    .exc_req (exc_req),
    .exc_code(exc_code),
    .pend    ({irq_ext, irq_sw, irq_tmr}),
    .src_en  (src_en),
    .gie     (gie),
    .take    (trap_take),
    .is_irq  (trap_irq),
    .code    (trap_code)
  );

  assign ret_take = ret_req & ~trap_take;
  assign wr_en    = csr_we & ~trap_take & ~ret_req;

  mtrap_csr #(.XLEN(XLEN), .CODE_W(CODE_W)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_take(trap_take),
    .trap_irq (trap_irq),
    .trap_code(trap_code),
    .trap_pc  (trap_pc),
    .ret_take (ret_take),
    .wr_en    (wr_en),
    .sel      (csr_sel),
    .wdata    (csr_wdata),
    .rdata    (csr_rdata),
    .gie      (gie),
    .src_en   (src_en),
    .vec_base (vec_base),
    .vec_mode (vec_mode),
    .epc      (epc_val),
    .cause    (cause_val)
  );

  mtrap_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
    .base  (vec_base),
    .mode  (vec_mode),
    .is_irq(trap_irq),
    .code  (trap_code),
    .pc    (target_pc)
  );

  assign redir_valid = trap_take | ret_req;
  assign redir_pc    = trap_take ? target_pc : epc_val;
endmodule

// File: rtl/mtrap_chk.sv
module mtrap_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            ret_req,
  input logic [XLEN-1:0] trap_pc,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            trap_take,
  input logic            trap_irq,
  input logic            gie,
  input logic [XLEN-3:0] vec_base,
  input logic [1:0]      vec_mode,
  input logic [XLEN-1:0] epc_val,
  input logic [XLEN-1:0] cause_val
);
  p_exc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (redir_valid && trap_take && !trap_irq));
  p_cause_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (cause_val[XLEN-1] == $past(trap_irq)));
  p_epc_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    epc_val[1:0] == 2'b00);
  p_epc_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (epc_val[XLEN-1:2] == $past(trap_pc[XLEN-1:2])));
  p_entry_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !gie);
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_irq) |-> gie);
  p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && vec_mode == 2'd0) |-> (redir_pc == {vec_base, 2'b00}));
  p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_take) |-> (redir_valid && redir_pc == epc_val));
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_mode[1] == 1'b0);
endmodule

bind mtrap_unit mtrap_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_req    (exc_req),
  .ret_req    (ret_req),
  .trap_pc    (trap_pc),
  .redir_valid(redir_valid),
  .redir_pc   (redir_pc),
  .trap_take  (trap_take),
  .trap_irq   (trap_irq),
  .gie        (gie),
  .vec_base   (vec_base),
  .vec_mode   (vec_mode),
  .epc_val    (epc_val),
  .cause_val  (cause_val)
);

// File: tb/sim_mtrap_unit.sv
`timescale 1ns/1ps
module sim_mtrap_unit;
  localparam int XL = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 1'b0;
  logic [CW-1:0] exc_code = '0;
  logic [XL-1:0] trap_pc = '0;
  logic irq_ext = 1'b0, irq_sw = 1'b0, irq_tmr = 1'b0;
  logic ret_req = 1'b0;
  logic csr_we = 1'b0;
  logic [2:0] csr_sel = '0;
  logic [XL-1:0] csr_wdata = '0;
  logic [XL-1:0] csr_rdata;
  logic redir_valid;
  logic [XL-1:0] redir_pc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtrap_unit #(.XLEN(XL), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .trap_pc(trap_pc), .irq_ext(irq_ext), .irq_sw(irq_sw), .irq_tmr(irq_tmr),
    .ret_req(ret_req), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [XL-1:0] d);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    step();
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [XL-1:0] d);
    csr_sel = s;
    #1;
    d = csr_rdata;
  endtask

  function automatic logic [XL-1:0] en_value(input logic [2:0] m);
    // m bit0 timer (bit 7), bit1 software (bit 3), bit2 external (bit 11)
    return (XL'(m[0]) << 7) | (XL'(m[1]) << 3) | (XL'(m[2]) << 11);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [XL-1:0] v, pcv, base, vecw;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk($sformatf("R1 reset sel %0d", s), v, '0);
    end
    chk("R1 redir idle", XL'(redir_valid), '0);

    // R3 mode legalisation
    for (int m = 0; m < 4; m++) begin
      wr(3'd2, 16'hA5F0 | XL'(m));
      rd(3'd2, v);
      chk($sformatf("R3 vec mode %0d", m), v, 16'hA5F0 | ((m == 1) ? 16'h1 : 16'h0));
    end

    // R12 unimplemented bits, R6 software write alignment
    wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R12 status bits", v, 16'h0088);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R12 enable bits", v, 16'h0888);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); chk("R6 epc write", v, 16'hFFFC);
    for (int s = 5; s < 8; s++) begin
      wr(3'(s), 16'hFFFF); rd(3'(s), v);
      chk($sformatf("R12 sel %0d reads zero", s), v, '0);
    end
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);

    // exception sweep over both modes, with discarded cause write (R11)
    for (int m = 0; m < 2; m++) begin
      vecw = 16'h4A10 | XL'(m);
      wr(3'd2, vecw);
      base = vecw & 16'hFFFC;
      for (int c = 0; c < 16; c++) begin
        pcv = 16'h2001 + XL'(c) * 16'h0105;
        exc_req = 1'b1; exc_code = CW'(c); trap_pc = pcv;
        csr_we = 1'b1; csr_sel = 3'd3; csr_wdata = 16'hFFFF;
        #1;
        chk("R11 redirect same cycle", XL'(redir_valid), 16'h1);
        chk(m == 0 ? "R4 exception direct target" : "R5 exception vectored target", redir_pc, base);
        step();
        exc_req = 1'b0; csr_we = 1'b0;
        rd(3'd3, v); chk("R2 R11 exception cause", v, XL'(c));
        rd(3'd4, v); chk("R6 epc capture", v, pcv & 16'hFFFC);
      end
    end

    // R7 return: pie=1 ie=0, concurrent epc write discarded (R11)
    rd(3'd4, pcv);
    wr(3'd0, 16'h0080);
    ret_req = 1'b1; csr_we = 1'b1; csr_sel = 3'd4; csr_wdata = 16'h1234;
    #1;
    chk("R7 return valid", XL'(redir_valid), 16'h1);
    chk("R7 return target", redir_pc, pcv);
    step();
    ret_req = 1'b0; csr_we = 1'b0;
    rd(3'd0, v); chk("R7 status after return", v, 16'h0088);
    rd(3'd4, v); chk("R11 epc write discarded on return", v, pcv);
    wr(3'd0, 16'h0008);
    ret_req = 1'b1;
    step();
    ret_req = 1'b0;
    rd(3'd0, v); chk("R7 restore zero saved enable", v, 16'h0080);

    // interrupt sweep, vectored mode
    vecw = 16'h0801;
    wr(3'd2, vecw);
    base = 16'h0800;
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 8; e++) begin
        for (int p = 0; p < 8; p++) begin
          logic [2:0] live;
          int code;
          bit tk;
          wr(3'd0, XL'(g) << 3);
          wr(3'd1, en_value(3'(e)));
          live = 3'(p) & 3'(e) & {3{g[0]}};
          tk = (live != 3'b000);
          code = live[2] ? 11 : (live[1] ? 3 : 7);
          pcv = 16'h3000 + XL'(p * 4 + e);
          irq_tmr = p[0]; irq_sw = p[1]; irq_ext = p[2]; trap_pc = pcv;
          #1;
          chk($sformatf("R8 take g%0d e%0d p%0d", g, e, p), XL'(redir_valid), XL'(tk));
          if (tk) chk("R5 R10 vectored target", redir_pc, base + XL'(code) * 4);
          step();
          irq_tmr = 1'b0; irq_sw = 1'b0; irq_ext = 1'b0;
          if (tk) begin
            rd(3'd3, v); chk("R2 R10 interrupt cause", v, 16'h8000 | XL'(code));
            rd(3'd0, v); chk("R9 status after entry", v, 16'h0080);
          end else begin
            rd(3'd0, v); chk("R8 status untouched", v, XL'(g) << 3);
          end
        end
      end
    end

    // R10 exception beats all interrupts
    wr(3'd0, 16'h0008);
    wr(3'd1, 16'h0888);
    irq_tmr = 1'b1; irq_sw = 1'b1; irq_ext = 1'b1;
    exc_req = 1'b1; exc_code = 4'd5; trap_pc = 16'h5556;
    #1;
    chk("R10 exception wins target", redir_pc, base);
    step();
    exc_req = 1'b0; irq_tmr = 1'b0; irq_sw = 1'b0; irq_ext = 1'b0;
    rd(3'd3, v); chk("R10 exception wins cause", v, 16'h0005);
    rd(3'd0, v); chk("R9 saved enable set", v, 16'h0080);

    // R10 trap beats return; R4 direct-mode interrupt
    wr(3'd2, 16'h0C00);
    wr(3'd0, 16'h0008);
    irq_tmr = 1'b1; ret_req = 1'b1; trap_pc = 16'h6000;
    #1;
    chk("R4 direct interrupt target", redir_pc, 16'h0C00);
    step();
    irq_tmr = 1'b0; ret_req = 1'b0;
    rd(3'd4, v); chk("R10 trap over return epc", v, 16'h6000);
    rd(3'd3, v); chk("R2 timer cause", v, 16'h8007);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule